// File: doc/BRIEF.md
# Per-pin interrupt sense controller

This block turns 32 already-synchronized input pin levels into interrupt requests. Each pin has its own sense setting, which picks what counts as an event on that pin: a rising edge, a falling edge, both edges, a high level or a low level. When an event is seen on a pin whose detection is turned on, a pending flag for that pin is latched. The flag holds until software acknowledges it.

Pending flags pass through a per-pin interrupt enable and are folded into two request lines. One line serves pins 0 to 15 and the other serves pins 16 to 31, so the two halves can go to different interrupt inputs of a processor. Software reaches all of this through a simple 32-bit register bus with a combinational read port. The interrupt enable is changed through separate set and clear strobe addresses, so no read-modify-write is needed. Sense settings sit in four registers at 0x40 and up.

Top module: `pin_sense_irq`

## Requirements
- R1: While reset is asserted and right after it is released, every pending flag, detection enable, interrupt enable and sense field is 0. Both request outputs are low, and every register reads 0.
- R2: The low three bits of a pin's sense code select its event. 0 is a rising edge, 1 a falling edge, 2 a high level, 3 a low level and 4 either edge. Edges are judged against the pin level seen one cycle earlier, and that history register resets to 0. The event sets the pending flag at the next clock edge.
- R3: Pin n's sense code is bits 4*(n mod 8)+3 down to 4*(n mod 8) of the register at 0x40 + 4*(n/8), and all four registers read back what was written. Codes whose low three bits are 5, 6 or 7 never produce an event. Bit 3 of a code is stored but does not change detection.
- R4: Address 0x14 is a read/write detection enable with one bit per pin. A pin whose bit is 0 produces no new pending event, and pending flags it already holds are kept.
- R5: The edge history of a pin is updated every cycle, including while its detection is off. A level that rose while detection was off therefore gives no rising event once detection is turned on.
- R6: Writing 1s to 0x18 sets those pins' interrupt enable bits, and writing 1s to 0x1C clears them. Bits written as 0 are left unchanged. Reading 0x1C returns the enable bits, where 1 means unmasked.
- R7: Reading 0x20 returns the raw pending flags, and reading 0x24 returns the pending flags ANDed with the enables. Writes to 0x20 and 0x24 have no effect. Addresses 0x18, 0x28 and unmapped addresses read 0.
- R8: Writing 1s to 0x28 clears those pins' pending flags at the next clock edge. If an event for the same pin is detected in that same cycle, the flag stays set. A level-sensed pin whose level is still active therefore cannot be cleared.
- R9: The low request output is the OR of the enabled pending flags of pins 0 to 15, and the high request output is the same for pins 16 to 31. Both follow the registered state with no added delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_lvl | input | 32 | Synchronized pin levels |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe for the current address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address, combinational |
| irq_lo | output | 1 | Request for pins 0 to 15 |
| irq_hi | output | 1 | Request for pins 16 to 31 |

## Verification
The bench builds the block with its default parameters: 32 pins, 4-bit sense fields, an 8-bit address and a 32-bit data bus. With these values both request halves are present, all four sense registers exist, and every field boundary can be reached. Directed sequences cover each sense code on pins spread across all four sense registers. They also cover a clear that lands in the same cycle as a fresh edge, a held level that defeats a clear, and re-enabling detection on a pin that is already high. A long random phase then mixes sparse pin toggles with writes to every register, including undefined and asynchronous-flagged codes.

// File: rtl/pss_pkg.sv
package pss_pkg;

  // Register byte offsets. Software depends on these values.
  localparam int OFS_DETEN  = 'h14;
  localparam int OFS_UNMASK = 'h18;
  localparam int OFS_MASK   = 'h1C;
  localparam int OFS_RAW    = 'h20;
  localparam int OFS_MSKD   = 'h24;
  localparam int OFS_CLEAR  = 'h28;
  localparam int OFS_SENSE  = 'h40;

  // Number of sense-code bits that take part in detection.
  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    SNS_RISE = 3'd0,
    SNS_FALL = 3'd1,
    SNS_HIGH = 3'd2,
    SNS_LOW  = 3'd3,
    SNS_BOTH = 3'd4
  } sense_mode_e;

endpackage

// File: rtl/pss_regs.sv
module pss_regs
  import pss_pkg::*;
#(
  parameter int PIN_COUNT = 32,
  parameter int SENSE_W   = 4,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic                        bus_wr,
  input  logic [DATA_W-1:0]           bus_wdata,
  input  logic [PIN_COUNT-1:0]        pend_q,
  output logic [PIN_COUNT-1:0]        det_en_q,
  output logic [PIN_COUNT-1:0]        ien_q,
  output logic [PIN_COUNT-1:0]        clr_bits,
  output logic [PIN_COUNT*MODE_W-1:0] mode_bits,
  output logic [DATA_W-1:0]           bus_rdata
);

  localparam int FIELDS     = DATA_W / SENSE_W;
  localparam int SENSE_REGS = PIN_COUNT / FIELDS;

  logic [SENSE_REGS-1:0][DATA_W-1:0] sns_q, sns_d;
  logic [SENSE_REGS-1:0]             sns_we;
  logic [PIN_COUNT-1:0]              det_en_d, ien_d;
  logic                              det_en_we, ien_we;
  logic [PIN_COUNT-1:0]              wbits;

  assign wbits = bus_wdata[PIN_COUNT-1:0];

  function automatic logic hit(input int ofs);
    return bus_wr && (bus_addr == ADDR_W'(ofs));
  endfunction

  // Next-state logic
  always_comb begin
    det_en_we = hit(OFS_DETEN);
    det_en_d  = wbits;
    ien_we    = hit(OFS_UNMASK) || hit(OFS_MASK);
    ien_d     = hit(OFS_UNMASK) ? (ien_q | wbits) : (ien_q & ~wbits);
    for (int r = 0; r < SENSE_REGS; r++) begin
      sns_we[r] = hit(OFS_SENSE + 4 * r);
      sns_d[r]  = bus_wdata;
    end
  end

  assign clr_bits = hit(OFS_CLEAR) ? wbits : '0;

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      det_en_q <= '0;
      ien_q    <= '0;
      sns_q    <= '0;
    end else begin
      if (det_en_we) det_en_q <= det_en_d;
      if (ien_we)    ien_q    <= ien_d;
      for (int r = 0; r < SENSE_REGS; r++) begin
        if (sns_we[r]) sns_q[r] <= sns_d[r];
      end
    end
  end

  // Only the mode bits of each field reach detection. The flag bit is storage only.
  for (genvar p = 0; p < PIN_COUNT; p++) begin : g_mode
    assign mode_bits[p*MODE_W +: MODE_W] =
      sns_q[p / FIELDS][(p % FIELDS) * SENSE_W +: MODE_W];
  end

  // Read mux
  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_W'(OFS_DETEN): bus_rdata = DATA_W'(det_en_q);
      ADDR_W'(OFS_MASK):  bus_rdata = DATA_W'(ien_q);
      ADDR_W'(OFS_RAW):   bus_rdata = DATA_W'(pend_q);
      ADDR_W'(OFS_MSKD):  bus_rdata = DATA_W'(pend_q & ien_q);
      default:            bus_rdata = '0;
    endcase
    for (int r = 0; r < SENSE_REGS; r++) begin
      if (bus_addr == ADDR_W'(OFS_SENSE + 4 * r)) bus_rdata = sns_q[r];
    end
  end

endmodule

// File: rtl/pss_detect.sv
module pss_detect
  import pss_pkg::*;
#(
  parameter int PIN_COUNT = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [PIN_COUNT-1:0]        pin_lvl,
  input  logic [PIN_COUNT-1:0]        det_en,
  input  logic [PIN_COUNT*MODE_W-1:0] mode_bits,
  output logic [PIN_COUNT-1:0]        evt
);

  logic [PIN_COUNT-1:0] hist_q;
  logic [PIN_COUNT-1:0] rise, fall;

  assign rise = pin_lvl & ~hist_q;
  assign fall = ~pin_lvl & hist_q;

  // History is always loaded, whatever the enable says.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= pin_lvl;
  end

  for (genvar p = 0; p < PIN_COUNT; p++) begin : g_pin
    logic [MODE_W-1:0] mode;
    logic              hit;
    assign mode = mode_bits[p*MODE_W +: MODE_W];
    always_comb begin
      case (mode)
        SNS_RISE: hit = rise[p];
        SNS_FALL: hit = fall[p];
        SNS_HIGH: hit = pin_lvl[p];
        SNS_LOW:  hit = ~pin_lvl[p];
        SNS_BOTH: hit = rise[p] | fall[p];
        default:  hit = 1'b0;
      endcase
    end
    assign evt[p] = hit & det_en[p];
  end

endmodule

// File: rtl/pss_pending.sv
module pss_pending #(
  parameter int PIN_COUNT = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [PIN_COUNT-1:0] evt,
  input  logic [PIN_COUNT-1:0] clr_bits,
  input  logic [PIN_COUNT-1:0] ien,
  output logic [PIN_COUNT-1:0] pend_q,
  output logic                 irq_lo,
  output logic                 irq_hi
);

  localparam int HALF = PIN_COUNT / 2;

  logic [PIN_COUNT-1:0] pend_d, masked;

  // A fresh event outranks a clear in the same cycle.
  assign pend_d = (pend_q & ~clr_bits) | evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign masked = pend_q & ien;
  assign irq_lo = |masked[HALF-1:0];
  assign irq_hi = |masked[PIN_COUNT-1:HALF];

endmodule

// File: rtl/pin_sense_irq.sv
module pin_sense_irq
  import pss_pkg::*;
#(
  parameter int PIN_COUNT = 32,
  parameter int SENSE_W   = 4,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [PIN_COUNT-1:0] pin_lvl,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_wr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  output logic                 irq_lo,
  output logic                 irq_hi
);

  logic [PIN_COUNT-1:0]        det_en_q, ien_q, clr_bits, evt, pend_q;
  logic [PIN_COUNT*MODE_W-1:0] mode_bits;

  pss_regs #(
    .PIN_COUNT(PIN_COUNT), .SENSE_W(SENSE_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .pend_q(pend_q), .det_en_q(det_en_q),
    .ien_q(ien_q), .clr_bits(clr_bits), .mode_bits(mode_bits),
    .bus_rdata(bus_rdata)
  );

  pss_detect #(.PIN_COUNT(PIN_COUNT)) u_detect (
    .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .det_en(det_en_q),
    .mode_bits(mode_bits), .evt(evt)
  );

  pss_pending #(.PIN_COUNT(PIN_COUNT)) u_pending (
    .clk(clk), .rst_n(rst_n), .evt(evt), .clr_bits(clr_bits), .ien(ien_q),
    .pend_q(pend_q), .irq_lo(irq_lo), .irq_hi(irq_hi)
  );

endmodule

// File: rtl/pss_checker.sv
module pss_checker
  import pss_pkg::*;
#(
  parameter int PIN_COUNT = 32,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic                 bus_wr,
  input logic [DATA_W-1:0]    bus_wdata,
  input logic [PIN_COUNT-1:0] pend_q,
  input logic [PIN_COUNT-1:0] ien_q,
  input logic [PIN_COUNT-1:0] det_en_q,
  input logic                 irq_lo,
  input logic                 irq_hi
);

  logic [PIN_COUNT-1:0] wbits;
  assign wbits = bus_wdata[PIN_COUNT-1:0];

  // R1: during reset, nothing is pending and no request is raised.
  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_quiet_R1: assert (pend_q == '0 && !irq_lo && !irq_hi)
        else $error("reset state not quiet");
    end
  end

  // R6: a mask strobe clears the written enable bits.
  assert_mask_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(OFS_MASK)) |=> ((ien_q & $past(wbits)) == '0));

  // R6: an unmask strobe sets the written enable bits.
  assert_unmask_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(OFS_UNMASK)) |=> ((ien_q & $past(wbits)) == $past(wbits)));

  // R8: with detection off everywhere, an acknowledge always clears.
  assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(OFS_CLEAR) && det_en_q == '0)
      |=> ((pend_q & $past(wbits)) == '0));

  // R4: with detection off everywhere, no flag newly sets.
  assert_no_new_event_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (det_en_q == '0) |=> ((pend_q & ~$past(pend_q)) == '0));

  // R9: with all interrupts masked, both request lines are low.
  assert_masked_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q == '0) |-> (!irq_lo && !irq_hi));

endmodule

bind pin_sense_irq pss_checker #(
  .PIN_COUNT(PIN_COUNT), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .pend_q(pend_q), .ien_q(ien_q),
  .det_en_q(det_en_q), .irq_lo(irq_lo), .irq_hi(irq_hi)
);

// File: tb/pin_sense_irq_test.sv
`timescale 1ns/1ps
module pin_sense_irq_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] pin_lvl;
  logic [7:0]  bus_addr;
  logic        bus_wr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq_lo, irq_hi;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  // Reference state
  bit [31:0] m_pend, m_ien, m_den, m_hist;
  bit [3:0]  m_sns [32];
  bit [31:0] cur;

  always #10 clk = ~clk;

  pin_sense_irq uut (
    .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_lo(irq_lo), .irq_hi(irq_hi)
  );

  function automatic bit [31:0] m_read(input bit [7:0] a);
    bit [31:0] v = 0;
    case (a)
      8'h14: v = m_den;
      8'h1C: v = m_ien;
      8'h20: v = m_pend;
      8'h24: v = m_pend & m_ien;
      8'h40, 8'h44, 8'h48, 8'h4C:
        for (int f = 0; f < 8; f++) v[4*f +: 4] = m_sns[(a - 8'h40) * 2 + f];
      default: v = 0;
    endcase
    return v;
  endfunction

  task automatic check(input string tag, input string what,
                       input bit [31:0] got, input bit [31:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic m_advance(input bit [31:0] pins, input bit wr,
                           input bit [7:0] a, input bit [31:0] wd);
    bit [31:0] ev = 0, clr = 0;
    for (int i = 0; i < 32; i++) begin
      bit r = pins[i] && !m_hist[i];
      bit f = !pins[i] && m_hist[i];
      bit h;
      case (m_sns[i][2:0])
        3'd0: h = r;
        3'd1: h = f;
        3'd2: h = pins[i];
        3'd3: h = !pins[i];
        3'd4: h = r || f;
        default: h = 0;
      endcase
      ev[i] = h && m_den[i];
    end
    if (wr && a == 8'h28) clr = wd;
    m_pend = (m_pend & ~clr) | ev;
    m_hist = pins;
    if (wr) begin
      case (a)
        8'h14: m_den = wd;
        8'h18: m_ien = m_ien | wd;
        8'h1C: m_ien = m_ien & ~wd;
        8'h40, 8'h44, 8'h48, 8'h4C:
          for (int f = 0; f < 8; f++) m_sns[(a - 8'h40) * 2 + f] = wd[4*f +: 4];
        default: ;
      endcase
    end
  endtask

  task automatic step(input bit wr, input bit [7:0] a, input bit [31:0] wd,
                      input string tag);
    bit [31:0] mk;
    @(negedge clk);
    pin_lvl = cur; bus_wr = wr; bus_addr = a; bus_wdata = wd;
    #1;
    mk = m_pend & m_ien;
    check(tag, "irq_lo (R9)", 32'(irq_lo), 32'(|mk[15:0]));
    check(tag, "irq_hi (R9)", 32'(irq_hi), 32'(|mk[31:16]));
    check(tag, $sformatf("rdata@%h", a), bus_rdata, m_read(a));
    m_advance(cur, wr, a, wd);
  endtask

  task automatic rd(input bit [7:0] a, input string tag);
    step(0, a, 0, tag);
  endtask

  task automatic wr(input bit [7:0] a, input bit [31:0] d, input string tag);
    step(1, a, d, tag);
  endtask

  task automatic setpin(input int i, input bit v, input string tag);
    cur[i] = v;
    step(0, 8'h20, 0, tag);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL R1 watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    bit [7:0] alist [11] = '{8'h14, 8'h18, 8'h1C, 8'h20, 8'h24, 8'h28,
                             8'h40, 8'h44, 8'h48, 8'h4C, 8'h30};
    rst_n = 0; cur = 0; pin_lvl = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    m_pend = 0; m_ien = 0; m_den = 0; m_hist = 0;
    for (int i = 0; i < 32; i++) m_sns[i] = 0;

    // R1: registers read 0 and no requests while in reset.
    for (int k = 0; k < 11; k++) begin
      @(negedge clk);
      pin_lvl = 32'hFFFF_FFFF; bus_addr = alist[k];
      #1;
      check("R1", "rdata in reset", bus_rdata, 0);
      check("R1", "irq in reset", 32'({irq_lo, irq_hi}), 0);
    end
    @(negedge clk); pin_lvl = 0; rst_n = 1;
    for (int k = 0; k < 11; k++) rd(alist[k], "R1");

    // R6: unmask everything; R4: enable detection.
    wr(8'h18, 32'hFFFF_FFFF, "R6");
    rd(8'h1C, "R6");
    wr(8'h14, 32'hFFFF_FFFF, "R4");
    // R2: rising edge on a low-half pin, then on a high-half pin.
    setpin(3, 1, "R2");
    rd(8'h20, "R2");
    setpin(20, 1, "R2");
    rd(8'h24, "R7");
    setpin(3, 0, "R2");
    // R8: acknowledge clears.
    wr(8'h28, 32'h0000_0008, "R8");
    rd(8'h20, "R8");
    wr(8'h28, 32'h0010_0000, "R8");
    rd(8'h20, "R9");

    // R3/R2: pin 5 level high, pin 12 level low, pin 27 both edges.
    wr(8'h40, 32'h0020_0000, "R3");
    wr(8'h44, 32'h0003_0000, "R3");
    wr(8'h4C, 32'h0000_4000, "R3");
    setpin(5, 1, "R2");
    wr(8'h28, 32'hFFFF_FFFF, "R8");   // level high still active: pin 5 stays set
    rd(8'h20, "R8");
    setpin(12, 1, "R2");
    wr(8'h28, 32'hFFFF_FFFF, "R8");
    setpin(5, 0, "R2");
    wr(8'h28, 32'hFFFF_FFFF, "R8");
    rd(8'h20, "R8");
    setpin(27, 1, "R2");
    wr(8'h28, 32'h0800_0000, "R8");
    setpin(27, 0, "R2");
    rd(8'h20, "R2");
    // Falling edge on pin 17: register 2, field 1 = code 1.
    wr(8'h48, 32'h0000_0010, "R3");
    setpin(17, 1, "R2");
    rd(8'h20, "R2");
    setpin(17, 0, "R2");
    rd(8'h20, "R2");
    wr(8'h28, 32'hFFFF_FFFF, "R8");

    // R3: undefined code on pin 0, then rising with the flag bit set.
    wr(8'h40, 32'h0020_000D, "R3");
    rd(8'h40, "R3");
    setpin(0, 1, "R3");
    setpin(0, 0, "R3");
    rd(8'h20, "R3");
    wr(8'h40, 32'h0020_0008, "R3");
    setpin(0, 1, "R3");
    rd(8'h20, "R3");
    wr(8'h28, 32'hFFFF_FFFF, "R8");

    // R4: pending kept while detection is off; no new events.
    setpin(9, 1, "R4");
    wr(8'h14, 32'hFFFF_FDFF, "R4");
    setpin(9, 0, "R4");
    setpin(9, 1, "R4");
    rd(8'h20, "R4");
    wr(8'h28, 32'h0000_0200, "R4");
    setpin(9, 0, "R4");
    setpin(9, 1, "R4");
    rd(8'h20, "R4");
    // R5: history tracked while off; enabling gives no event.
    wr(8'h14, 32'hFFFF_FFFF, "R5");
    rd(8'h20, "R5");
    rd(8'h20, "R5");
    setpin(9, 0, "R5");
    setpin(9, 1, "R5");
    rd(8'h20, "R5");

    // R8: acknowledge in the same cycle as a fresh edge.
    wr(8'h28, 32'hFFFF_FFFF, "R8");
    setpin(20, 0, "R8");
    cur[20] = 1;
    wr(8'h28, 32'h0010_0000, "R8");
    rd(8'h20, "R8");

    // R6/R9: mask the high half, then the low half.
    wr(8'h1C, 32'hFFFF_0000, "R6");
    rd(8'h1C, "R6");
    rd(8'h24, "R9");
    wr(8'h1C, 32'h0000_FFFF, "R6");
    rd(8'h24, "R9");
    wr(8'h18, 32'h0010_0000, "R6");
    rd(8'h1C, "R6");

    // R7: read-only and write-only addresses.
    wr(8'h20, 32'h0000_0000, "R7");
    wr(8'h24, 32'hFFFF_FFFF, "R7");
    rd(8'h20, "R7");
    rd(8'h18, "R7");
    rd(8'h28, "R7");
    rd(8'h30, "R7");

    // Random phase covering all requirements together (R2 R3 R4 R6 R7 R8 R9).
    for (int n = 0; n < 4000; n++) begin
      int k = $urandom_range(0, 11);
      if ($urandom_range(0, 2) == 0) cur[$urandom_range(0, 31)] ^= 1'b1;
      case (k)
        0: wr(8'h14, $urandom, "R4 random");
        1: wr(8'h18, $urandom, "R6 random");
        2: wr(8'h1C, $urandom & $urandom, "R6 random");
        3: wr(8'h28, $urandom, "R8 random");
        4: wr(8'h40 + 8'($urandom_range(0, 3) * 4), $urandom, "R3 random");
        5: wr(8'h20, $urandom, "R7 random");
        default: rd(alist[$urandom_range(0, 10)], "R2 random");
      endcase
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule